// File: doc/BRIEF.md
# Queue-Occupancy Voltage/Frequency Level Controller

This controller sits beside the queue that separates a producing clock domain from a consuming clock domain. It reads the queue's fill count every cycle and reports a voltage/frequency setting for each domain as a percentage of full speed. A queue that stays almost full shows that the producer is being held back, so the producer's setting is lowered. A queue that stays almost empty shows that the consumer is starved, so the consumer's setting is lowered. The clock generators, supply regulators and the crossing logic that act on these settings are outside this block.

A setting is lowered only after the fill count has stayed in the same edge band for a long, unbroken run of cycles. Each lowering removes one fixed step, and the setting stops at a floor. When the fill count reaches a watermark deep in the opposite band, the slowed domain goes straight back to full speed. Every change of a setting opens a fixed settle window. During that window a busy flag is raised and the fill count is not acted on.

The design has four named states. In `ST_EVEN` both domains run at full speed. In `ST_PROD_SLOW` only the producer is lowered, and in `ST_CONS_SLOW` only the consumer is lowered. `ST_SETTLE` is the settle window. The transitions are:

- lower-producer, from `ST_EVEN` or `ST_PROD_SLOW` into `ST_SETTLE`;
- lower-consumer, from `ST_EVEN` or `ST_CONS_SLOW` into `ST_SETTLE`;
- restore-producer, from `ST_PROD_SLOW` into `ST_SETTLE`;
- restore-consumer, from `ST_CONS_SLOW` into `ST_SETTLE`;
- settle-done, from `ST_SETTLE` back to the watching state that matches the current settings.

Top module: `dvs_occ_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, both level outputs read 100 and `settle_busy` is 0.
- R2: The near-empty band is a fill count of at most CAPACITY*NEAR_PCT/100, which is 6 with the defaults. The near-full band is a fill count of at least CAPACITY minus that amount, which is 58. Fill counts between the two bands, such as 7 and 57, never lower any setting.
- R3: In `ST_EVEN`, once the fill count has been near-full on DWELL_CYCLES consecutive clock edges, the producer level drops by STEP_PCT on the last of those edges.
- R4: In `ST_EVEN`, once the fill count has been near-empty on DWELL_CYCLES consecutive clock edges, the consumer level drops by STEP_PCT on the last of those edges.
- R5: A single cycle outside the band resets the dwell run, so the next lowering needs a full new run of DWELL_CYCLES edges.
- R6: Each lowering removes exactly STEP_PCT. Lowering stops at FLOOR_PCT, which is 50, and a level never reads below FLOOR_PCT or above 100.
- R7: In `ST_PROD_SLOW`, a fill count at or below LOW_WM restores the producer to 100 on the next edge. In `ST_CONS_SLOW`, a fill count at or above HIGH_WM restores the consumer to 100 on the next edge.
- R8: At most one level is below 100 at any time. While the producer is lowered, a near-empty fill count above LOW_WM leaves both levels unchanged.
- R9: `settle_busy` rises on the same edge as any level change and stays high for exactly SETTLE_CYCLES cycles.
- R10: While `settle_busy` is high, the fill count is ignored. After the window closes, a restore acts on the first edge, and a lowering needs a fresh dwell run of DWELL_CYCLES edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occupancy | input | $clog2(CAPACITY+1) | Current fill count of the decoupling queue |
| prod_level | output | LVL_W | Producer domain setting, in percent of full speed |
| cons_level | output | LVL_W | Consumer domain setting, in percent of full speed |
| settle_busy | output | 1 | High while a settle window is open |

## Verification
The bench places the fill count exactly on the band edges (6, 7, 57 and 58). A design with an off-by-one band would lower a setting where it must not, or miss a lowering where it must happen. It breaks a dwell run one cycle short of expiry. A counter that pauses instead of restarting would then lower the setting too early. It also sends a restore condition in the middle of a settle window. A design that does not ignore input during settle would restore early, and one that sets the window length wrong would restore a cycle off. Finally, it walks the producer down to the floor and then holds a near-empty fill count. A missing floor clamp would go below 50, and a missing interlock would lower the consumer as well.

// File: rtl/dvs_occ_pkg.sv
package dvs_occ_pkg;

    typedef enum logic [1:0] {
        ZONE_MID,
        ZONE_LOW,
        ZONE_HIGH
    } zone_t;

    typedef enum logic [1:0] {
        ST_EVEN,
        ST_PROD_SLOW,
        ST_CONS_SLOW,
        ST_SETTLE
    } state_t;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_PROD_DOWN,
        ACT_CONS_DOWN,
        ACT_PROD_UP,
        ACT_CONS_UP
    } act_t;

endpackage

// File: rtl/dvs_zone_detect.sv
module dvs_zone_detect
    import dvs_occ_pkg::*;
#(
    parameter int OCC_W       = 7,
    parameter int NEAR_LO_MAX = 6,
    parameter int NEAR_HI_MIN = 58,
    parameter int LOW_WM      = 2,
    parameter int HIGH_WM     = 62
) (
    input  logic [OCC_W-1:0] occ,
    output zone_t            zone,
    output logic             at_low_wm,
    output logic             at_high_wm
);
    localparam logic [OCC_W-1:0] LO_EDGE = OCC_W'(NEAR_LO_MAX);
    localparam logic [OCC_W-1:0] HI_EDGE = OCC_W'(NEAR_HI_MIN);
    localparam logic [OCC_W-1:0] LO_MARK = OCC_W'(LOW_WM);
    localparam logic [OCC_W-1:0] HI_MARK = OCC_W'(HIGH_WM);

    always_comb begin
        if (occ <= LO_EDGE)      zone = ZONE_LOW;
        else if (occ >= HI_EDGE) zone = ZONE_HIGH;
        else                     zone = ZONE_MID;
        at_low_wm  = (occ <= LO_MARK);
        at_high_wm = (occ >= HI_MARK);
    end
endmodule

// File: rtl/dvs_dwell_timer.sv
module dvs_dwell_timer
    import dvs_occ_pkg::*;
#(
    parameter int DWELL = 50000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  zone_t zone,
    output logic  expired
);
    localparam int CW = $clog2(DWELL + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DWELL);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] run;
    zone_t         last_q;

    always_comb begin
        if (zone == ZONE_MID)    run = '0;
        else if (zone != last_q) run = CW'(1);
        else if (cnt_q == LIMIT) run = cnt_q;
        else                     run = cnt_q + 1'b1;
        expired = en && (zone != ZONE_MID) && (run >= LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q  <= '0;
            last_q <= ZONE_MID;
        end else begin
            cnt_q  <= run;
            last_q <= zone;
        end
    end
endmodule

// File: rtl/dvs_settle_timer.sv
module dvs_settle_timer #(
    parameter int SETTLE = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [SW-1:0] END_CNT = SW'(SETTLE - 1);

    logic [SW-1:0] cnt_q;

    assign last = run && (cnt_q == END_CNT);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dvs_occ_ctrl.sv
module dvs_occ_ctrl
    import dvs_occ_pkg::*;
#(
    parameter int CAPACITY      = 64,
    parameter int NEAR_PCT      = 10,
    parameter int DWELL_CYCLES  = 50000,
    parameter int SETTLE_CYCLES = 3000,
    parameter int STEP_PCT      = 10,
    parameter int FLOOR_PCT     = 50,
    parameter int LOW_WM        = 2,
    parameter int HIGH_WM       = 62,
    parameter int LVL_W         = 7,
    localparam int OCC_W        = $clog2(CAPACITY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occupancy,
    output logic [LVL_W-1:0] prod_level,
    output logic [LVL_W-1:0] cons_level,
    output logic             settle_busy
);
    localparam int NEAR_BAND = CAPACITY * NEAR_PCT / 100;
    localparam logic [LVL_W-1:0] FULL  = LVL_W'(100);
    localparam logic [LVL_W-1:0] FLOOR = LVL_W'(FLOOR_PCT);
    localparam logic [LVL_W-1:0] STEP  = LVL_W'(STEP_PCT);

    state_t state_q, state_d;
    act_t   act;
    zone_t  zone;
    logic   at_low_wm, at_high_wm, dwell_hit, settle_last;
    logic [LVL_W-1:0] prod_q, cons_q;

    dvs_zone_detect #(
        .OCC_W      (OCC_W),
        .NEAR_LO_MAX(NEAR_BAND),
        .NEAR_HI_MIN(CAPACITY - NEAR_BAND),
        .LOW_WM     (LOW_WM),
        .HIGH_WM    (HIGH_WM)
    ) u_zone (
        .occ       (occupancy),
        .zone      (zone),
        .at_low_wm (at_low_wm),
        .at_high_wm(at_high_wm)
    );

    dvs_dwell_timer #(.DWELL(DWELL_CYCLES)) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state_q != ST_SETTLE),
        .zone   (zone),
        .expired(dwell_hit)
    );

    dvs_settle_timer #(.SETTLE(SETTLE_CYCLES)) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_SETTLE),
        .last (settle_last)
    );

    // decision for this cycle
    always_comb begin
        act = ACT_HOLD;
        unique case (state_q)
            ST_EVEN: begin
                if (dwell_hit && zone == ZONE_HIGH)     act = ACT_PROD_DOWN;
                else if (dwell_hit && zone == ZONE_LOW) act = ACT_CONS_DOWN;
            end
            ST_PROD_SLOW: begin
                if (at_low_wm) act = ACT_PROD_UP;
                else if (dwell_hit && zone == ZONE_HIGH && prod_q > FLOOR)
                    act = ACT_PROD_DOWN;
            end
            ST_CONS_SLOW: begin
                if (at_high_wm) act = ACT_CONS_UP;
                else if (dwell_hit && zone == ZONE_LOW && cons_q > FLOOR)
                    act = ACT_CONS_DOWN;
            end
            ST_SETTLE: act = ACT_HOLD;
            default:   act = ACT_HOLD;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (act != ACT_HOLD) begin
            state_d = ST_SETTLE;
        end else if (state_q == ST_SETTLE && settle_last) begin
            if (prod_q != FULL)      state_d = ST_PROD_SLOW;
            else if (cons_q != FULL) state_d = ST_CONS_SLOW;
            else                     state_d = ST_EVEN;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EVEN;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= FULL;
            cons_q <= FULL;
        end else begin
            unique case (act)
                ACT_PROD_DOWN: prod_q <= prod_q - STEP;
                ACT_CONS_DOWN: cons_q <= cons_q - STEP;
                ACT_PROD_UP:   prod_q <= FULL;
                ACT_CONS_UP:   cons_q <= FULL;
                default:       ;
            endcase
        end
    end

    assign prod_level  = prod_q;
    assign cons_level  = cons_q;
    assign settle_busy = (state_q == ST_SETTLE);
endmodule

// File: rtl/dvs_occ_ctrl_chk.sv
module dvs_occ_ctrl_chk #(
    parameter int LVL_W     = 7,
    parameter int STEP_PCT  = 10,
    parameter int FLOOR_PCT = 50
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] prod_level,
    input logic [LVL_W-1:0] cons_level,
    input logic             settle_busy
);
    localparam logic [LVL_W-1:0] FULL  = LVL_W'(100);
    localparam logic [LVL_W-1:0] FLOOR = LVL_W'(FLOOR_PCT);
    localparam logic [LVL_W-1:0] STEP  = LVL_W'(STEP_PCT);

    AST_ONE_DOMAIN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !(prod_level != FULL && cons_level != FULL)); // R8

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        prod_level >= FLOOR && prod_level <= FULL &&
        cons_level >= FLOOR && cons_level <= FULL); // R6

    AST_PROD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_level != $past(prod_level)) |->
        (prod_level == $past(prod_level) - STEP || prod_level == FULL)); // R6

    AST_CONS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_level != $past(cons_level)) |->
        (cons_level == $past(cons_level) - STEP || cons_level == FULL)); // R6

    AST_CHANGE_OPENS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_level != $past(prod_level) || cons_level != $past(cons_level))
        |-> settle_busy); // R9

    AST_QUIET_IN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(settle_busy) && settle_busy) |->
        ($stable(prod_level) && $stable(cons_level))); // R10
endmodule

bind dvs_occ_ctrl dvs_occ_ctrl_chk #(
    .LVL_W    (LVL_W),
    .STEP_PCT (STEP_PCT),
    .FLOOR_PCT(FLOOR_PCT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prod_level (prod_level),
    .cons_level (cons_level),
    .settle_busy(settle_busy)
);

// File: tb/dvs_occ_ctrl_test.sv
module dvs_occ_ctrl_test;
    localparam int D = 20;
    localparam int S = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] occ = 7'd32;
    logic [6:0] prod_level, cons_level;
    logic       settle_busy;

    int checks = 0;
    int fails  = 0;
    int cur_p  = 100;
    int cur_c  = 100;
    bit done   = 1'b0;
    logic [13:0] exp_q[$];

    always #2 clk = ~clk;

    dvs_occ_ctrl #(
        .DWELL_CYCLES (D),
        .SETTLE_CYCLES(S)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .occupancy  (occ),
        .prod_level (prod_level),
        .cons_level (cons_level),
        .settle_busy(settle_busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_lvls(input string tag, input int p, input int c);
        check(prod_level == p, {tag, " producer level"}, prod_level, p);
        check(cons_level == c, {tag, " consumer level"}, cons_level, c);
    endtask

    task automatic expect_busy(input string tag, input int b);
        check(settle_busy == b, {tag, " busy"}, settle_busy, b);
    endtask

    task automatic hold_steady(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            expect_lvls(tag, cur_p, cur_c);
        end
    endtask

    // change expected on the n-th negedge from now
    task automatic step_to(input string tag, input int n, input int p, input int c);
        exp_q.push_back({7'(p), 7'(c)});
        hold_steady(tag, n - 1);
        @(negedge clk);
        expect_lvls(tag, p, c);
        expect_busy(tag, 1);
        cur_p = p;
        cur_c = c;
    endtask

    // scoreboard monitor
    logic [13:0] prev = {7'd100, 7'd100};
    always @(negedge clk) begin
        if (rst_n && {prod_level, cons_level} != prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 scoreboard unexpected change", {prod_level, cons_level}, prev);
            end else begin
                logic [13:0] e;
                e = exp_q.pop_front();
                check({prod_level, cons_level} == e, "R6 scoreboard order",
                      {prod_level, cons_level}, e);
            end
            prev = {prod_level, cons_level};
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_lvls("R1 in reset", 100, 100);
        expect_busy("R1 in reset", 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_lvls("R1 after reset", 100, 100);
        expect_busy("R1 after reset", 0);

        hold_steady("R2 mid", 40);
        occ = 7'd7;
        hold_steady("R2 just above empty band", D + 5);
        occ = 7'd57;
        hold_steady("R2 just below full band", D + 5);

        occ = 7'd58;
        hold_steady("R5 broken run", D - 1);
        occ = 7'd32;
        hold_steady("R5 gap", 1);
        occ = 7'd58;
        step_to("R3 producer lowered", D, 90, 100);

        for (int i = 0; i < S - 1; i++) begin
            @(negedge clk);
            expect_busy("R9 window", 1);
        end
        @(negedge clk);
        expect_busy("R9 window closed", 0);
        step_to("R10 fresh dwell", D, 80, 100);

        step_to("R6 step", S + D, 70, 100);
        step_to("R6 step", S + D, 60, 100);
        step_to("R6 step", S + D, 50, 100);
        hold_steady("R6 floor", S + D + 10);

        occ = 7'd4;
        hold_steady("R8 interlock", S + D + 5);

        occ = 7'd1;
        step_to("R7 producer restore", 1, 100, 100);
        step_to("R4 consumer lowered", S + D, 100, 90);

        occ = 7'd63;
        hold_steady("R10 ignored in settle", S);
        step_to("R7 consumer restore", 1, 100, 100);
        step_to("R8 producer after restore", S + D, 90, 100);

        @(negedge clk);
        check(exp_q.size() == 0, "R6 scoreboard leftover", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule